// File: doc/BRIEF.md
# Indirect Configuration Port Decoder

This block sits on a host I/O-port bus and opens up the configuration registers of devices on bus zero through two windows. A 32-bit address port holds a latch that names an enable bit, a bus, a device/function selector and a dword-aligned register. A four-byte data port then carries the actual configuration read or write. Each data access becomes a single-cycle request to one downstream target. The request carries the byte offset inside that target's configuration space, the access size and the write data.

Targets are attached through a registration port. Each distinct selector is bound to the next free target handle, up to a fixed number of targets. Writes that land on the identity and class bytes of the standard header are filtered out before they reach any target. A data shadow register keeps the last value that moved through the data window.

Top module: `cfg_port_bridge`

## Requirements
- R1: The address latch is at port 0x0CF8. It loads `io_wdata` only on a write of size 4 to exactly that port. A write of any other size to it leaves the latch unchanged, and so does a write to any other port.
- R2: A read of port 0x0CF8 returns the latch when `io_size` is 4. For any other size it returns 0x0000FFFF.
- R3: The data window covers ports 0x0CFC to 0x0CFF. An access there is valid only when latch bit 31 is 1 and latch bits 23:16 are zero.
  - The selector is latch bits 15:8.
  - `tgt_off` is latch bits 7:2 followed by port bits 1:0.
  - A forwarded access raises exactly one bit of `tgt_req`: the bit whose index is the handle mapped to the selector.
  - `tgt_wr`, `tgt_size` and `tgt_wdata` copy the host access.
- R4: A data-window read returns the addressed target's data in the same cycle. It returns 0xFFFFFFFF and raises no `tgt_req` in three cases: the latch is invalid, the selector has no target, or the size is not 1, 2 or 4.
- R5: Reads at any offset are forwarded. A write is forwarded only when the offset is 4 to 7, 12, 13, or 15 and above. Writes to offsets 0 to 3, 8 to 11 and 14 raise no `tgt_req` and leave `cfg_shadow` unchanged.
- R6: A `reg_req` pulse with `reg_sel` is reported one cycle later with `reg_done`=1.
  - On success, `reg_ok`=1 and `reg_handle` carries the handle. Handles are granted 0, 1, 2, ... in order.
  - Registration fails (`reg_ok`=0) when the selector already has a target or when all `MAX_TGT` handles are used.
- R7: Reset clears the address latch to zero, clears `cfg_shadow` to zero, and unassigns every selector.
- R8: After a forwarded write, `cfg_shadow` equals `io_wdata` shifted left by 8 times port bits 1:0. After any data-window read, it equals the returned value. Nothing else changes it.
- R9: An access to a port outside 0x0CF8 and 0x0CFC–0x0CFF changes no state, raises no `tgt_req`, and a read of it returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Host I/O access strobe |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_port | input | PORT_W | I/O port address |
| io_size | input | 3 | Access size in bytes |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Host read data, same cycle |
| reg_req | input | 1 | Registration request |
| reg_sel | input | 8 | Device/function selector to register |
| reg_done | output | 1 | Registration result valid |
| reg_ok | output | 1 | Registration succeeded |
| reg_handle | output | HW | Handle granted |
| tgt_req | output | MAX_TGT | One-hot target request strobe |
| tgt_wr | output | 1 | Target write flag |
| tgt_off | output | 8 | Byte offset in target configuration space |
| tgt_size | output | 3 | Access size |
| tgt_wdata | output | 32 | Target write data |
| tgt_rdata | input | 32*MAX_TGT | Read data of each target, handle-indexed |
| cfg_shadow | output | 32 | Last data-window value |

## Verification
The assertions check, on every cycle, several rules that hold regardless of stimulus:
- `tgt_req` is never more than one-hot, and it is raised only for a data-window port while the latch is enabled and on bus zero.
- Forwarded writes never target a protected offset.
- An invalid-latch data read always returns all ones.
- The latch and the shadow stay still when their ports are not touched.
- Granted handles stay in range.

Only the bench scenarios can show the rest: the exact offset assembly, the handle ordering and the failure cases of registration, the byte-lane shift into the shadow, and the clearing of the selector map by reset.

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int          MAX_TGT   = 4,
  parameter int          PORT_W    = 16,
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC,
  localparam int         HW        = (MAX_TGT > 1) ? $clog2(MAX_TGT) : 1,
  localparam int         CW        = $clog2(MAX_TGT + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_req,
  input  logic                  io_wr,
  input  logic [PORT_W-1:0]     io_port,
  input  logic [2:0]            io_size,
  input  logic [31:0]           io_wdata,
  output logic [31:0]           io_rdata,
  input  logic                  reg_req,
  input  logic [7:0]            reg_sel,
  output logic                  reg_done,
  output logic                  reg_ok,
  output logic [HW-1:0]         reg_handle,
  output logic [MAX_TGT-1:0]    tgt_req,
  output logic                  tgt_wr,
  output logic [7:0]            tgt_off,
  output logic [2:0]            tgt_size,
  output logic [31:0]           tgt_wdata,
  input  logic [32*MAX_TGT-1:0] tgt_rdata,
  output logic [31:0]           cfg_shadow
);

  localparam int NSEL = 256;

  logic [31:0]   addr_q;
  logic [31:0]   shadow_q;
  logic [NSEL-1:0] map_vld;
  logic [HW-1:0] map_hdl [NSEL];
  logic [CW-1:0] used_q;

  logic          hit_addr, hit_data, cfg_on, size_ok, mapped, go, wr_ok, fwd;
  logic [7:0]    sel, off;
  logic [HW-1:0] hdl;
  logic [31:0]   trd [MAX_TGT];
  logic [31:0]   data_rd;

  assign hit_addr = io_req && (io_port == ADDR_PORT[PORT_W-1:0]);
  assign hit_data = io_req && (io_port[PORT_W-1:2] == DATA_PORT[PORT_W-1:2]);
  assign cfg_on   = addr_q[31] && (addr_q[23:16] == 8'h00);
  assign sel      = addr_q[15:8];
  assign off      = {addr_q[7:2], io_port[1:0]};
  assign size_ok  = (io_size == 3'd1) || (io_size == 3'd2) || (io_size == 3'd4);
  assign mapped   = map_vld[sel];
  assign hdl      = map_hdl[sel];
  assign go       = hit_data && cfg_on && mapped && size_ok;

  assign wr_ok = (off[7:2] == 6'd1) || (off == 8'd12) || (off == 8'd13) || (off >= 8'd15);
  assign fwd   = go && (!io_wr || wr_ok);

  genvar g;
  generate
    for (g = 0; g < MAX_TGT; g++) begin : g_tgt
      assign trd[g]     = tgt_rdata[g*32 +: 32];
      assign tgt_req[g] = fwd && (hdl == HW'(g));
    end
  endgenerate

  assign tgt_wr    = io_wr;
  assign tgt_off   = off;
  assign tgt_size  = io_size;
  assign tgt_wdata = io_wdata;

  assign data_rd = go ? trd[hdl] : 32'hFFFF_FFFF;

  always_comb begin
    if (hit_addr)
      io_rdata = (io_size == 3'd4) ? addr_q : 32'h0000_FFFF;
    else if (hit_data)
      io_rdata = data_rd;
    else
      io_rdata = 32'hFFFF_FFFF;
  end

  assign cfg_shadow = shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (hit_addr && io_wr && io_size == 3'd4)
        addr_q <= io_wdata;
      if (hit_data && !io_wr)
        shadow_q <= data_rd;
      else if (fwd && io_wr)
        shadow_q <= io_wdata << {io_port[1:0], 3'b000};
    end
  end

  logic reg_take;
  assign reg_take = reg_req && !map_vld[reg_sel] && (used_q < CW'(MAX_TGT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_vld    <= '0;
      used_q     <= '0;
      reg_done   <= 1'b0;
      reg_ok     <= 1'b0;
      reg_handle <= '0;
    end else begin
      reg_done <= reg_req;
      reg_ok   <= reg_take;
      if (reg_take) begin
        map_vld[reg_sel] <= 1'b1;
        used_q           <= used_q + CW'(1);
        reg_handle       <= HW'(used_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (reg_take)
      map_hdl[reg_sel] <= HW'(used_q);
  end

endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk #(
  parameter int          MAX_TGT   = 4,
  parameter int          PORT_W    = 16,
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC,
  localparam int         HW        = (MAX_TGT > 1) ? $clog2(MAX_TGT) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               io_req,
  input logic               io_wr,
  input logic [PORT_W-1:0]  io_port,
  input logic [2:0]         io_size,
  input logic [31:0]        io_rdata,
  input logic               reg_done,
  input logic               reg_ok,
  input logic [HW-1:0]      reg_handle,
  input logic [MAX_TGT-1:0] tgt_req,
  input logic               tgt_wr,
  input logic [7:0]         tgt_off,
  input logic [31:0]        addr_q,
  input logic [31:0]        shadow_q
);

  logic in_win;
  assign in_win = io_req && (io_port[PORT_W-1:2] == DATA_PORT[PORT_W-1:2]);

  AST_TGT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_req)); // R3

  AST_TGT_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (|tgt_req) |-> (in_win && addr_q[31] && addr_q[23:16] == 8'h00)); // R3

  AST_WR_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tgt_req) && tgt_wr) |-> !(tgt_off <= 8'd3 || (tgt_off >= 8'd8 && tgt_off <= 8'd11) || tgt_off == 8'd14)); // R5

  AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !io_wr && !addr_q[31]) |-> (io_rdata == 32'hFFFF_FFFF)); // R4

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && io_wr && io_port == ADDR_PORT[PORT_W-1:0] && io_size == 3'd4) |=> $stable(addr_q)); // R1

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |=> $stable(shadow_q)); // R8

  AST_HANDLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_done && reg_ok) |-> (int'(reg_handle) < MAX_TGT)); // R6

endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(
  .MAX_TGT(MAX_TGT), .PORT_W(PORT_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr), .io_port(io_port),
  .io_size(io_size), .io_rdata(io_rdata), .reg_done(reg_done), .reg_ok(reg_ok),
  .reg_handle(reg_handle), .tgt_req(tgt_req), .tgt_wr(tgt_wr), .tgt_off(tgt_off),
  .addr_q(addr_q), .shadow_q(shadow_q)
);

// File: tb/sim_cfg_port_bridge.sv
module sim_cfg_port_bridge;
  localparam int MAX_TGT = 4;
  localparam int HW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_req = 1'b0, io_wr = 1'b0;
  logic [15:0] io_port = '0;
  logic [2:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic reg_req = 1'b0;
  logic [7:0] reg_sel = '0;
  logic reg_done, reg_ok;
  logic [HW-1:0] reg_handle;
  logic [MAX_TGT-1:0] tgt_req;
  logic tgt_wr;
  logic [7:0] tgt_off;
  logic [2:0] tgt_size;
  logic [31:0] tgt_wdata;
  logic [32*MAX_TGT-1:0] tgt_rdata;
  logic [31:0] cfg_shadow;

  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  for (genvar i = 0; i < MAX_TGT; i++) begin : g_model
    assign tgt_rdata[i*32 +: 32] = {16'hC0DE, tgt_off, 8'(i)};
  end

  cfg_port_bridge #(.MAX_TGT(MAX_TGT)) u0 (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr), .io_port(io_port),
    .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata), .reg_req(reg_req),
    .reg_sel(reg_sel), .reg_done(reg_done), .reg_ok(reg_ok), .reg_handle(reg_handle),
    .tgt_req(tgt_req), .tgt_wr(tgt_wr), .tgt_off(tgt_off), .tgt_size(tgt_size),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata), .cfg_shadow(cfg_shadow)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] port;
    logic [2:0]  size;
    logic [31:0] wdata;
    logic [31:0] rd;
    logic [3:0]  tgt;
    logic [7:0]  off;
    logic [31:0] sh;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0CF8, 3'd4, 32'h80000804, 32'h0,         4'h0, 8'h00, 32'h00000000},
    '{1'b0, 16'h0CF8, 3'd4, 32'h0,        32'h80000804,  4'h0, 8'h00, 32'h00000000},
    '{1'b0, 16'h0CF8, 3'd2, 32'h0,        32'h0000FFFF,  4'h0, 8'h00, 32'h00000000},
    '{1'b1, 16'h0CF8, 3'd2, 32'h0,        32'h0,         4'h0, 8'h00, 32'h00000000},
    '{1'b0, 16'h0CF8, 3'd4, 32'h0,        32'h80000804,  4'h0, 8'h00, 32'h00000000},
    '{1'b0, 16'h0CFC, 3'd4, 32'h0,        32'hC0DE0400,  4'h1, 8'h04, 32'hC0DE0400},
    '{1'b0, 16'h0CFE, 3'd1, 32'h0,        32'hC0DE0600,  4'h1, 8'h06, 32'hC0DE0600},
    '{1'b1, 16'h0CFD, 3'd1, 32'h000000AB, 32'h0,         4'h1, 8'h05, 32'h0000AB00},
    '{1'b1, 16'h0CF8, 3'd4, 32'h80001000, 32'h0,         4'h0, 8'h00, 32'h0000AB00},
    '{1'b1, 16'h0CFC, 3'd4, 32'h12345678, 32'h0,         4'h0, 8'h00, 32'h0000AB00},
    '{1'b1, 16'h0CFE, 3'd2, 32'h00001234, 32'h0,         4'h0, 8'h00, 32'h0000AB00},
    '{1'b0, 16'h0CFC, 3'd4, 32'h0,        32'hC0DE0001,  4'h2, 8'h00, 32'hC0DE0001},
    '{1'b1, 16'h0CF8, 3'd4, 32'h8000180C, 32'h0,         4'h0, 8'h00, 32'hC0DE0001},
    '{1'b1, 16'h0CFC, 3'd1, 32'h00000055, 32'h0,         4'h4, 8'h0C, 32'h00000055},
    '{1'b1, 16'h0CFE, 3'd1, 32'h00000066, 32'h0,         4'h0, 8'h00, 32'h00000055},
    '{1'b1, 16'h0CFF, 3'd1, 32'h00000077, 32'h0,         4'h4, 8'h0F, 32'h77000000},
    '{1'b1, 16'h0CFD, 3'd1, 32'h00000088, 32'h0,         4'h4, 8'h0D, 32'h00008800},
    '{1'b1, 16'h0CF8, 3'd4, 32'h80000808, 32'h0,         4'h0, 8'h00, 32'h00008800},
    '{1'b1, 16'h0CFC, 3'd4, 32'h00000099, 32'h0,         4'h0, 8'h00, 32'h00008800},
    '{1'b0, 16'h0CFC, 3'd4, 32'h0,        32'hC0DE0800,  4'h1, 8'h08, 32'hC0DE0800},
    '{1'b0, 16'h0CFC, 3'd3, 32'h0,        32'hFFFFFFFF,  4'h0, 8'h00, 32'hFFFFFFFF},
    '{1'b1, 16'h0CF8, 3'd4, 32'h80010804, 32'h0,         4'h0, 8'h00, 32'hFFFFFFFF},
    '{1'b0, 16'h0CFC, 3'd4, 32'h0,        32'hFFFFFFFF,  4'h0, 8'h00, 32'hFFFFFFFF},
    '{1'b1, 16'h0CF8, 3'd4, 32'h00000804, 32'h0,         4'h0, 8'h00, 32'hFFFFFFFF},
    '{1'b0, 16'h0CFD, 3'd1, 32'h0,        32'hFFFFFFFF,  4'h0, 8'h00, 32'hFFFFFFFF},
    '{1'b1, 16'h0CF8, 3'd4, 32'h80002804, 32'h0,         4'h0, 8'h00, 32'hFFFFFFFF},
    '{1'b0, 16'h0CFC, 3'd4, 32'h0,        32'hFFFFFFFF,  4'h0, 8'h00, 32'hFFFFFFFF},
    '{1'b1, 16'h0CFC, 3'd4, 32'h00000055, 32'h0,         4'h0, 8'h00, 32'hFFFFFFFF},
    '{1'b1, 16'h0CF8, 3'd4, 32'h80002004, 32'h0,         4'h0, 8'h00, 32'hFFFFFFFF},
    '{1'b0, 16'h0CFD, 3'd2, 32'h0,        32'hC0DE0503,  4'h8, 8'h05, 32'hC0DE0503},
    '{1'b0, 16'h0060, 3'd4, 32'h0,        32'hFFFFFFFF,  4'h0, 8'h00, 32'hC0DE0503},
    '{1'b1, 16'h0CF9, 3'd4, 32'h00000000, 32'h0,         4'h0, 8'h00, 32'hC0DE0503},
    '{1'b0, 16'h0CF8, 3'd4, 32'h0,        32'h80002004,  4'h0, 8'h00, 32'hC0DE0503},
    '{1'b1, 16'h0CFD, 3'd0, 32'h00000011, 32'h0,         4'h0, 8'h00, 32'hC0DE0503}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input vec_t v, input string req);
    @(negedge clk);
    io_req = 1'b1; io_wr = v.wr; io_port = v.port; io_size = v.size; io_wdata = v.wdata;
    #1;
    if (!v.wr) chk(req, "io_rdata", io_rdata, v.rd);
    chk(req, "tgt_req", 32'(tgt_req), 32'(v.tgt));
    if (v.tgt != 4'h0) begin
      chk(req, "tgt_off", 32'(tgt_off), 32'(v.off));
      chk(req, "tgt_size", 32'(tgt_size), 32'(v.size));
      chk(req, "tgt_wr", 32'(tgt_wr), 32'(v.wr));
      if (v.wr) chk(req, "tgt_wdata", tgt_wdata, v.wdata);
    end
    @(posedge clk); #1;
    io_req = 1'b0;
    chk(req, "cfg_shadow", cfg_shadow, v.sh);
  endtask

  task automatic do_reg(input logic [7:0] s, input logic exp_ok, input logic [HW-1:0] exp_h);
    @(negedge clk);
    reg_req = 1'b1; reg_sel = s;
    @(posedge clk); #1;
    reg_req = 1'b0;
    chk("R6", "reg_done", 32'(reg_done), 32'd1);
    chk("R6", "reg_ok", 32'(reg_ok), 32'(exp_ok));
    if (exp_ok) chk("R6", "reg_handle", 32'(reg_handle), 32'(exp_h));
  endtask

  function automatic vec_t mk(input logic wr, input logic [15:0] p, input logic [2:0] sz,
                              input logic [31:0] wd, input logic [31:0] rd, input logic [3:0] t,
                              input logic [7:0] o, input logic [31:0] sh);
    mk = '{wr, p, sz, wd, rd, t, o, sh};
  endfunction

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R7 reset state
    chk("R7", "cfg_shadow", cfg_shadow, 32'h0);
    access(mk(1'b0, 16'h0CF8, 3'd4, 0, 32'h0, 4'h0, 8'h0, 32'h0), "R7");
    // R6 registration order and failures
    do_reg(8'h08, 1'b1, 2'd0);
    do_reg(8'h10, 1'b1, 2'd1);
    do_reg(8'h08, 1'b0, 2'd0);
    do_reg(8'h18, 1'b1, 2'd2);
    do_reg(8'h20, 1'b1, 2'd3);
    do_reg(8'h28, 1'b0, 2'd0);
    // R1 R2 R3 R4 R5 R8 R9 table
    for (int i = 0; i < NV; i++) access(VEC[i], $sformatf("vec%0d R1/R2/R3/R4/R5/R8/R9", i));
    // R7 mid-run reset clears latch, shadow and map
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    chk("R7", "cfg_shadow", cfg_shadow, 32'h0);
    access(mk(1'b0, 16'h0CF8, 3'd4, 0, 32'h0, 4'h0, 8'h0, 32'h0), "R7");
    access(mk(1'b1, 16'h0CF8, 3'd4, 32'h80000804, 0, 4'h0, 8'h0, 32'h0), "R7");
    access(mk(1'b0, 16'h0CFC, 3'd4, 0, 32'hFFFFFFFF, 4'h0, 8'h0, 32'hFFFFFFFF), "R7");
    do_reg(8'h08, 1'b1, 2'd0);
    access(mk(1'b0, 16'h0CFC, 3'd4, 0, 32'hC0DE0400, 4'h1, 8'h04, 32'hC0DE0400), "R6");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule